// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block is a clocked sequencer placed between a single-request host handshake and an external asynchronous static RAM of 2048 bytes. The host raises a request with a direction bit, an 11-bit address and a write byte. The controller latches them and steps through a fixed series of phases: address setup, strobe pulse, data hold and recovery. Each phase lasts a parameter number of clock cycles. At the end it returns a one-cycle acknowledge, and for a read it also returns the byte it sampled.

All RAM control lines are active low and come straight from flops. Chip select stays high whenever no strobe phase is running, so the memory idles in standby. For a write, chip select and write enable fall on the same edge. This keeps the memory's output drivers off and so avoids bus contention. Both lines then rise together, so the recovery interval starts from one edge. The data bus is modelled as a driven value plus a drive enable, with the returning byte on its own input. A parameter chooses whether output enable stays high during writes. If it does not, the write pulse is lengthened to cover driver turn-off plus data setup.

Top module: `sram_seq_ctrl`

## Requirements
- R1: During and right after reset, `sram_cs_n`, `sram_we_n` and `sram_oe_n` are 1, `sram_dq_oe` is 0, `ack` is 0 and `rdata` is 0.
- R2: `sram_cs_n` is 1 and `sram_dq_oe` is 0 in every cycle in which the controller is idle.
- R3: The address on `sram_addr` is the `req_addr` captured on the accepting edge. `sram_addr` changes only in a cycle where `sram_cs_n` was 1 both before and after the change. Host inputs changed after acceptance have no effect on the access.
- R4: For a write (`req_we` = 1), `sram_cs_n` and `sram_we_n` fall on the same edge and stay low together for exactly WP_EFF cycles, and the captured byte is stored at the captured address. WP_EFF equals PULSE_CYC when OE_HIGH_ON_WRITE = 1, and max(PULSE_CYC, TURNOFF_CYC + DSETUP_CYC) otherwise.
- R5: During a write, `sram_dq_oe` is 1 and `sram_dq_out` holds the captured byte from the first pulse cycle through HOLD_CYC cycles after `sram_we_n` rises. After that, `sram_dq_oe` returns to 0.
- R6: For a read (`req_we` = 0), `sram_we_n` stays 1 while `sram_cs_n` and `sram_oe_n` are low together for exactly ACCESS_CYC cycles. `rdata` takes the value of `sram_dq_in` in the last of those cycles.
- R7: With OE_HIGH_ON_WRITE = 1, `sram_oe_n` stays 1 throughout a write. With OE_HIGH_ON_WRITE = 0, it is 0 during the write pulse.
- R8: `ack` is high for exactly one cycle. That cycle is the last of RECOV_CYC cycles with all strobes high. Those cycles follow the hold phase on a write, and the strobe release on a read. The next request is accepted only on a later edge.
- R9: Between the accepting edge and the fall of `sram_cs_n`, there are exactly SETUP_CYC cycles with the address driven and all strobes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Host request, held until `ack` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | Host byte address |
| req_wdata | input | 8 | Host write byte |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte returned by the last read |
| sram_addr | output | 11 | RAM address lines |
| sram_cs_n | output | 1 | RAM chip select, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_dq_out | output | 8 | Byte driven onto the RAM data bus |
| sram_dq_oe | output | 1 | Drive enable for `sram_dq_out` |
| sram_dq_in | input | 8 | Byte read back from the RAM data bus |

## Verification
A wrong phase counter shows up within one access as a strobe run that is too short or too long. The bench model measures the run and, for reads, returns a garbage byte if the read is sampled early. A wrong captured direction or address shows on the pins in the first strobe cycle. The corruption is visible on the next read of that location, a few cycles later. A stuck sequencer shows as a missing acknowledge within the per-access cycle limit. Bus contention or an address moving under active strobes is flagged by the memory model on the cycle it happens.

// File: rtl/sram_seq_pkg.sv
// Shared types and helpers for the asynchronous SRAM access controller.
package sram_seq_pkg;

    // Access phases; one phase is active per clock cycle.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SETUP   = 3'd1,
        ST_WPULSE  = 3'd2,
        ST_WHOLD   = 3'd3,
        ST_RACCESS = 3'd4,
        ST_RECOV   = 3'd5
    } seq_state_t;

    // Larger of two cycle counts.
    function automatic int unsigned cyc_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Down-counter that times one access phase.
// Assumes: load is raised only once the previous count has expired.
// done is high while the count is zero, i.e. in the last cycle of a phase.
module sram_phase_timer #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    // Load a new phase length, or count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

    // R9 (phase lengths rely on reloads only after expiry)
    load_after_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> done);

endmodule

// File: rtl/sram_seq_fsm.sv
// Phase sequencer: accepts one host request at a time and walks it through
// setup, strobe, hold and recovery phases, each timed by sram_phase_timer.
// Assumes: all cycle parameters are at least 1; req is held until ack.
module sram_seq_fsm
    import sram_seq_pkg::*;
#(
    parameter int unsigned SETUP_CYC  = 1,
    parameter int unsigned WP_EFF     = 2,
    parameter int unsigned ACCESS_CYC = 2,
    parameter int unsigned HOLD_CYC   = 1,
    parameter int unsigned RECOV_CYC  = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       host_we,
    output logic       accept,
    output logic       capture,
    output logic       ack,
    output seq_state_t nxt_state
);

    localparam int unsigned MAX_CYC = cyc_max(cyc_max(cyc_max(SETUP_CYC, WP_EFF),
                                               cyc_max(ACCESS_CYC, HOLD_CYC)), RECOV_CYC);
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] LD_SETUP  = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_WPULSE = CNT_W'(WP_EFF - 1);
    localparam logic [CNT_W-1:0] LD_ACCESS = CNT_W'(ACCESS_CYC - 1);
    localparam logic [CNT_W-1:0] LD_HOLD   = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] LD_RECOV  = CNT_W'(RECOV_CYC - 1);

    if (SETUP_CYC == 0 || WP_EFF == 0 || ACCESS_CYC == 0 ||
        HOLD_CYC == 0 || RECOV_CYC == 0) begin : g_bad_cfg
        $error("sram_seq_fsm: every cycle count must be at least 1");
    end

    seq_state_t       state_q;
    logic             wr_q;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_done;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    // Next phase and timer reload for the phase being entered.
    always_comb begin
        nxt_state = state_q;
        t_load    = 1'b0;
        t_val     = '0;
        case (state_q)
            ST_IDLE: if (req) begin
                nxt_state = ST_SETUP;
                t_load    = 1'b1;
                t_val     = LD_SETUP;
            end
            ST_SETUP: if (t_done) begin
                t_load = 1'b1;
                if (wr_q) begin
                    nxt_state = ST_WPULSE;
                    t_val     = LD_WPULSE;
                end else begin
                    nxt_state = ST_RACCESS;
                    t_val     = LD_ACCESS;
                end
            end
            ST_WPULSE: if (t_done) begin
                nxt_state = ST_WHOLD;
                t_load    = 1'b1;
                t_val     = LD_HOLD;
            end
            ST_WHOLD, ST_RACCESS: if (t_done) begin
                nxt_state = ST_RECOV;
                t_load    = 1'b1;
                t_val     = LD_RECOV;
            end
            ST_RECOV: if (t_done) begin
                nxt_state = ST_IDLE;
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= nxt_state;
    end

    // Direction of the access in flight, captured on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)      wr_q <= 1'b0;
        else if (accept) wr_q <= host_we;
    end

    assign accept  = (state_q == ST_IDLE) && req;
    assign capture = (state_q == ST_RACCESS) && t_done;
    assign ack     = (state_q == ST_RECOV) && t_done;

    // R8
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R8
    ack_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (state_q == ST_IDLE));

endmodule

// File: rtl/sram_pin_drv.sv
// Pin stage: latches the host address and data on acceptance, registers the
// RAM strobes from the next phase so every pin leaves a flop, and captures
// read data at the end of the access phase.
// Assumes: nxt_state comes from sram_seq_fsm in the same cycle.
module sram_pin_drv
    import sram_seq_pkg::*;
#(
    parameter int unsigned ADDR_W           = 11,
    parameter int unsigned DATA_W           = 8,
    parameter bit          OE_HIGH_ON_WRITE = 1'b1,
    parameter int unsigned WP_EFF           = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  seq_state_t        nxt_state,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr_o,
    output logic              cs_n_o,
    output logic              we_n_o,
    output logic              oe_n_o,
    output logic [DATA_W-1:0] dq_out_o,
    output logic              dq_oe_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int unsigned RUN_W = $clog2(WP_EFF + 1) + 1;

    logic nxt_wpulse;
    logic nxt_racc;
    logic nxt_oe_low;

    assign nxt_wpulse = (nxt_state == ST_WPULSE);
    assign nxt_racc   = (nxt_state == ST_RACCESS);

    // Output enable during a write follows the configured mode.
    if (OE_HIGH_ON_WRITE) begin : g_oe_hi
        assign nxt_oe_low = nxt_racc;
    end else begin : g_oe_lo
        assign nxt_oe_low = nxt_racc || nxt_wpulse;
    end

    // Latch host address and write byte only when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o   <= '0;
            dq_out_o <= '0;
        end else if (accept) begin
            addr_o   <= host_addr;
            dq_out_o <= host_wdata;
        end
    end

    // Register the strobes and bus drive for the phase being entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n_o  <= 1'b1;
            we_n_o  <= 1'b1;
            oe_n_o  <= 1'b1;
            dq_oe_o <= 1'b0;
        end else begin
            cs_n_o  <= !(nxt_wpulse || nxt_racc);
            we_n_o  <= !nxt_wpulse;
            oe_n_o  <= !nxt_oe_low;
            dq_oe_o <= nxt_wpulse || (nxt_state == ST_WHOLD);
        end
    end

    // Sample the returning byte at the end of the access phase.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_o <= '0;
        else if (capture) rdata_o <= dq_in;
    end

    // Length of the current write-enable low run, for the pulse check.
    logic [RUN_W-1:0] wp_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)       wp_run_q <= '0;
        else if (!we_n_o) wp_run_q <= wp_run_q + 1'b1;
        else              wp_run_q <= '0;
    end

    // R3
    addr_move_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(addr_o) |-> (cs_n_o && $past(cs_n_o)));

    // R4
    we_within_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n_o |-> !cs_n_o);

    // R4
    wpulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n_o) |-> (wp_run_q == RUN_W'(WP_EFF)));

    // R5
    data_driven_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n_o |-> dq_oe_o);

    // R2
    no_drive_when_reading_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n_o && we_n_o) |-> (!cs_n_o && !dq_oe_o));

    if (OE_HIGH_ON_WRITE) begin : g_oe_chk
        // R7
        oe_high_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !we_n_o |-> oe_n_o);
    end

endmodule

// File: rtl/sram_seq_ctrl.sv
// Top of the asynchronous SRAM access controller: a phase sequencer and a
// registered pin stage. Host requests are taken one at a time; the RAM is
// deselected whenever no strobe phase is running.
// Assumes: host holds req and its fields until ack; cycle counts >= 1.
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int unsigned ADDR_W           = 11,
    parameter int unsigned DATA_W           = 8,
    parameter int unsigned SETUP_CYC        = 1,
    parameter int unsigned PULSE_CYC        = 2,
    parameter int unsigned ACCESS_CYC       = 2,
    parameter int unsigned HOLD_CYC         = 1,
    parameter int unsigned RECOV_CYC        = 1,
    parameter int unsigned TURNOFF_CYC      = 1,
    parameter int unsigned DSETUP_CYC       = 1,
    parameter bit          OE_HIGH_ON_WRITE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);

    localparam int unsigned WP_EFF = OE_HIGH_ON_WRITE ? PULSE_CYC
                                   : cyc_max(PULSE_CYC, TURNOFF_CYC + DSETUP_CYC);

    logic       accept;
    logic       capture;
    seq_state_t nxt_state;

    sram_seq_fsm #(
        .SETUP_CYC  (SETUP_CYC),
        .WP_EFF     (WP_EFF),
        .ACCESS_CYC (ACCESS_CYC),
        .HOLD_CYC   (HOLD_CYC),
        .RECOV_CYC  (RECOV_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .host_we   (req_we),
        .accept    (accept),
        .capture   (capture),
        .ack       (ack),
        .nxt_state (nxt_state)
    );

    sram_pin_drv #(
        .ADDR_W           (ADDR_W),
        .DATA_W           (DATA_W),
        .OE_HIGH_ON_WRITE (OE_HIGH_ON_WRITE),
        .WP_EFF           (WP_EFF)
    ) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .capture    (capture),
        .nxt_state  (nxt_state),
        .host_addr  (req_addr),
        .host_wdata (req_wdata),
        .dq_in      (sram_dq_in),
        .addr_o     (sram_addr),
        .cs_n_o     (sram_cs_n),
        .we_n_o     (sram_we_n),
        .oe_n_o     (sram_oe_n),
        .dq_out_o   (sram_dq_out),
        .dq_oe_o    (sram_dq_oe),
        .rdata_o    (rdata)
    );

endmodule

// File: tb/sram_seq_ctrl_bench.sv
// Behavioural 2K x 8 RAM that measures strobe runs and counts protocol breaks.
module sram_bench_model #(
    parameter int ACC = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [10:0] addr,
    input  logic        cs_n,
    input  logic        we_n,
    input  logic        oe_n,
    input  logic [7:0]  dq_out,
    input  logic        dq_oe,
    input  logic        ack,
    output logic [7:0]  dq_in,
    output int          viol,
    output int          last_wp,
    output int          last_hold,
    output int          last_rd,
    output int          last_tail,
    output logic        oe_low_wr
);
    logic [7:0]  mem [0:2047];
    int          wp_run, hold_run, rd_run, rd_low, tail_run;
    logic [10:0] addr_prev;
    logic        both_low_prev;

    function automatic logic [7:0] init_byte(input int i);
        return 8'((i * 13) ^ (i >> 3) ^ 8'h6C);
    endfunction

    initial for (int i = 0; i < 2048; i++) mem[i] = init_byte(i);

    assign dq_in = (!cs_n && !oe_n && we_n && rd_low >= ACC - 1) ? mem[addr] : 8'hEE;

    always @(posedge clk) begin
        int v;
        v = 0;
        if (!rst_n) begin
            viol <= 0; wp_run <= 0; hold_run <= 0; rd_run <= 0; rd_low <= 0;
            tail_run <= 0; last_wp <= 0; last_hold <= 0; last_rd <= 0;
            last_tail <= 0; oe_low_wr <= 1'b0; addr_prev <= addr; both_low_prev <= 1'b0;
        end else begin
            if (!cs_n && !we_n) begin
                mem[addr] <= dq_out;
                if (!dq_oe) v++;
            end
            if (!we_n && cs_n) v++;
            if (addr != addr_prev && ((!cs_n && !we_n) || both_low_prev)) v++;
            if (dq_oe && !cs_n && !oe_n && we_n) v++;
            viol <= viol + v;
            addr_prev <= addr;
            both_low_prev <= !cs_n && !we_n;
            if (!we_n) begin
                wp_run <= wp_run + 1;
                if (wp_run == 0) oe_low_wr <= !oe_n;
                else if (!oe_n) oe_low_wr <= 1'b1;
            end else if (wp_run > 0) begin
                last_wp <= wp_run; wp_run <= 0;
            end
            if (we_n && dq_oe) hold_run <= hold_run + 1;
            else if (!dq_oe && hold_run > 0) begin
                last_hold <= hold_run; hold_run <= 0;
            end
            if (!cs_n && we_n) begin
                rd_run <= rd_run + 1; rd_low <= rd_low + 1;
            end else begin
                if (rd_run > 0) begin last_rd <= rd_run; rd_run <= 0; end
                rd_low <= 0;
            end
            if (!cs_n) tail_run <= 0;
            else if (ack) begin last_tail <= tail_run + 1; tail_run <= 0; end
            else tail_run <= tail_run + 1;
        end
    end
endmodule

// Bench: two controllers, one holding output enable high during writes and
// one leaving it low (stretched pulse), each with its own RAM model.
module sram_seq_ctrl_bench;
    localparam int CLK_P = 10;
    localparam int A_SETUP = 1, A_PULSE = 2, A_ACC = 2, A_HOLD = 1, A_REC = 1, A_TOFF = 1, A_DS = 1;
    localparam int B_SETUP = 2, B_PULSE = 1, B_ACC = 3, B_HOLD = 2, B_REC = 2, B_TOFF = 2, B_DS = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_a = 1'b0, req_b = 1'b0, we_h = 1'b0;
    logic [10:0] addr_h = '0;
    logic [7:0]  wdata_h = '0;
    int errors = 0, checks = 0;

    logic ack_a, ack_b, cs_a, cs_b, we_a, we_b, oe_a, oe_b, dqoe_a, dqoe_b;
    logic [7:0] rdata_a, rdata_b, dqo_a, dqo_b, dqi_a, dqi_b;
    logic [10:0] addr_a, addr_b;
    int viol_a, viol_b, wp_a, wp_b, hold_a, hold_b, rd_a, rd_b, tail_a, tail_b;
    logic oel_a, oel_b;
    logic [7:0] shadow_a [0:2047];
    logic [7:0] shadow_b [0:2047];

    always #(CLK_P / 2) clk = ~clk;

    sram_seq_ctrl #(.SETUP_CYC(A_SETUP), .PULSE_CYC(A_PULSE), .ACCESS_CYC(A_ACC),
        .HOLD_CYC(A_HOLD), .RECOV_CYC(A_REC), .TURNOFF_CYC(A_TOFF), .DSETUP_CYC(A_DS),
        .OE_HIGH_ON_WRITE(1'b1)) u_sram_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req_a), .req_we(we_h), .req_addr(addr_h),
        .req_wdata(wdata_h), .ack(ack_a), .rdata(rdata_a), .sram_addr(addr_a),
        .sram_cs_n(cs_a), .sram_we_n(we_a), .sram_oe_n(oe_a), .sram_dq_out(dqo_a),
        .sram_dq_oe(dqoe_a), .sram_dq_in(dqi_a));

    sram_seq_ctrl #(.SETUP_CYC(B_SETUP), .PULSE_CYC(B_PULSE), .ACCESS_CYC(B_ACC),
        .HOLD_CYC(B_HOLD), .RECOV_CYC(B_REC), .TURNOFF_CYC(B_TOFF), .DSETUP_CYC(B_DS),
        .OE_HIGH_ON_WRITE(1'b0)) u_sram_seq_ctrl_oelow (
        .clk(clk), .rst_n(rst_n), .req(req_b), .req_we(we_h), .req_addr(addr_h),
        .req_wdata(wdata_h), .ack(ack_b), .rdata(rdata_b), .sram_addr(addr_b),
        .sram_cs_n(cs_b), .sram_we_n(we_b), .sram_oe_n(oe_b), .sram_dq_out(dqo_b),
        .sram_dq_oe(dqoe_b), .sram_dq_in(dqi_b));

    sram_bench_model #(.ACC(A_ACC)) u_ram_a (.clk(clk), .rst_n(rst_n), .addr(addr_a),
        .cs_n(cs_a), .we_n(we_a), .oe_n(oe_a), .dq_out(dqo_a), .dq_oe(dqoe_a), .ack(ack_a),
        .dq_in(dqi_a), .viol(viol_a), .last_wp(wp_a), .last_hold(hold_a), .last_rd(rd_a),
        .last_tail(tail_a), .oe_low_wr(oel_a));

    sram_bench_model #(.ACC(B_ACC)) u_ram_b (.clk(clk), .rst_n(rst_n), .addr(addr_b),
        .cs_n(cs_b), .we_n(we_b), .oe_n(oe_b), .dq_out(dqo_b), .dq_oe(dqoe_b), .ack(ack_b),
        .dq_in(dqi_b), .viol(viol_b), .last_wp(wp_b), .last_hold(hold_b), .last_rd(rd_b),
        .last_tail(tail_b), .oe_low_wr(oel_b));

    function automatic logic [7:0] init_byte(input int i);
        return 8'((i * 13) ^ (i >> 3) ^ 8'h6C);
    endfunction

    // Expected write-pulse length from the stretch rule of R4 / R7.
    function automatic int exp_wp(input bit sel);
        if (!sel) return A_PULSE;
        return (B_PULSE > B_TOFF + B_DS) ? B_PULSE : B_TOFF + B_DS;
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic txn(input bit sel, input bit w, input logic [10:0] a, input logic [7:0] d);
        int cyc, setup_n;
        bit seen_low, done_f;
        logic [7:0] got_rd;
        @(posedge clk); #1;
        we_h = w; addr_h = a; wdata_h = d;
        if (sel) req_b = 1'b1; else req_a = 1'b1;
        cyc = 0; setup_n = 0; seen_low = 0; done_f = 0; got_rd = '0;
        while (!done_f) begin
            @(negedge clk);
            cyc++;
            if (cyc == 2) begin   // R3: scramble host inputs after acceptance
                addr_h = 11'($urandom); wdata_h = 8'($urandom); we_h = ~w;
            end
            if (!seen_low) begin
                if (sel ? cs_b : cs_a) setup_n++;
                else begin
                    seen_low = 1;
                    chk("R3 address at select", int'(sel ? addr_b : addr_a), int'(a));
                end
            end
            if (sel ? ack_b : ack_a) begin
                done_f = 1;
                got_rd = sel ? rdata_b : rdata_a;
                if (sel) req_b = 1'b0; else req_a = 1'b0;
            end else if (cyc > 400) begin
                chk("R8 ack watchdog", 0, 1);
                done_f = 1;
                req_a = 1'b0; req_b = 1'b0;
            end
        end
        chk("R9 setup cycles", setup_n, (sel ? B_SETUP : A_SETUP) + 1);
        @(posedge clk); @(negedge clk);
        chk("R8 ack single cycle", int'(sel ? ack_b : ack_a), 0);
        if (w) begin
            if (sel) shadow_b[a] = d; else shadow_a[a] = d;
            chk("R4 write pulse length", sel ? wp_b : wp_a, exp_wp(sel));
            chk("R5 data hold after strobe", sel ? hold_b : hold_a, sel ? B_HOLD : A_HOLD);
            chk("R7 oe low during write", int'(sel ? oel_b : oel_a), sel ? 1 : 0);
            chk("R8 tail after write", sel ? tail_b : tail_a,
                sel ? B_HOLD + B_REC : A_HOLD + A_REC);
        end else begin
            chk("R6 read data", int'(got_rd), int'(sel ? shadow_b[a] : shadow_a[a]));
            chk("R6 access length", sel ? rd_b : rd_a, sel ? B_ACC : A_ACC);
            chk("R8 tail after read", sel ? tail_b : tail_a, sel ? B_REC : A_REC);
        end
        chk("R2 deselected when idle", int'(sel ? cs_b : cs_a), 1);
        chk("R2 bus released when idle", int'(sel ? dqoe_b : dqoe_a), 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        chk("watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 2048; i++) begin
            shadow_a[i] = init_byte(i);
            shadow_b[i] = init_byte(i);
        end
        repeat (4) @(negedge clk);
        // R1: reset state on both controllers
        chk("R1 cs_n reset", int'(cs_a & cs_b), 1);
        chk("R1 we_n reset", int'(we_a & we_b), 1);
        chk("R1 oe_n reset", int'(oe_a & oe_b), 1);
        chk("R1 dq_oe reset", int'(dqoe_a | dqoe_b), 0);
        chk("R1 ack reset", int'(ack_a | ack_b), 0);
        chk("R1 rdata reset", int'(rdata_a | rdata_b), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cs_n after reset", int'(cs_a & cs_b), 1);

        // Directed corners: address extremes, untouched location, overwrite.
        for (int s = 0; s < 2; s++) begin
            txn(s[0], 1'b1, 11'h000, 8'hA5);
            txn(s[0], 1'b1, 11'h7FF, 8'h3C);
            txn(s[0], 1'b0, 11'h000, 8'h00);
            txn(s[0], 1'b0, 11'h7FF, 8'h00);
            txn(s[0], 1'b0, 11'h123, 8'h00);
            txn(s[0], 1'b1, 11'h040, 8'hFF);
            txn(s[0], 1'b1, 11'h040, 8'h00);
            txn(s[0], 1'b0, 11'h040, 8'h00);
        end

        // Constrained random mix over a small hot set plus the full range.
        for (int i = 0; i < 120; i++) begin
            logic [10:0] a;
            a = ($urandom % 4 == 0) ? 11'($urandom) : {7'd0, 4'($urandom)};
            txn(i[0], 1'($urandom), a, 8'($urandom));
        end

        chk("R3 R4 R5 protocol breaks controller A", viol_a, 0);
        chk("R3 R4 R5 protocol breaks controller B", viol_b, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule